// File: doc/BRIEF.md
# Three-State Phase Detector with Lock Monitor

This block compares two divided clock streams (a reference and a feedback divider output) and decides, at each comparison, which one leads. When the reference edge arrives first it asserts a pump-up enable; when the feedback edge arrives first it asserts a pump-down enable. Once the lagging edge also arrives, both enables are cleared on the following clock, so that the pump sources or sinks charge only for the measured phase gap. All signals are sampled on one fast system clock, so the phase gap is measured in whole clock cycles.

A lock monitor counts how many cycles each gap lasts and compares that count with a window that is set by a parameter. A run of consecutive comparisons inside the window raises a lock flag, and a single comparison outside it drops the flag again. A tristate input silences both pump enables and holds the lock monitor in its cleared state. A two-bit current code selects one of four pump-current levels. A new code is loaded by a strobe and is applied only while the pump is idle, so the current never changes while charge is being transferred. A busy output tells the divider update logic when the pump is active.

Top module: `pfd_lock`

## Requirements
- R1: A rising edge on `ref_in` while idle asserts `pump_up` from the next clock. It stays asserted, with `pump_dn` low, until the `div_in` edge is registered. For a lead of d cycles, `pump_up` is high alone for exactly d sampled cycles.
- R2: A rising edge on `div_in` while idle asserts `pump_dn` in the same way. For a lag of d cycles of `ref_in`, `pump_dn` is high alone for exactly d sampled cycles.
- R3: When both enables are high, both are cleared on the next clock. Each comparison therefore shows exactly one cycle with both high, including the case where the two edges arrive in the same cycle.
- R4: A comparison is within the window when its gap, in cycles, is strictly less than `WIN_CYC`. `locked` rises when `LOCK_RUN` consecutive comparisons (default 7) are within the window. It stays high while further comparisons stay within the window.
- R5: A comparison with a gap of `WIN_CYC` cycles or more clears the run count. It drops `locked` on the clock that ends that comparison.
- R6: While `tri_en` is high, `pump_up`, `pump_dn` and `locked` are low, and input edges have no effect on them. After `tri_en` falls, `LOCK_RUN` new in-window comparisons are needed before `locked` rises again.
- R7: The current code `cur_code` is {bit1 = low-current trim, bit0 = high-current trim}. It maps to the level index `cur_sel` (0 = lowest, 3 = highest) as follows: 00 gives 0, 10 gives 1, 01 gives 2 and 11 gives 3. After reset `cur_sel` is 0.
- R8: A code captured by `cur_load` is applied on the first clock edge after the strobe at which the pump is idle. `cur_sel` never changes on an edge where `busy` was high. With the pump idle, `cur_sel` shows the new level two clocks after the strobe edge.
- R9: `busy` is high exactly when `pump_up` or `pump_dn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ref_in | input | 1 | divided reference signal; its rising edges are compared |
| div_in | input | 1 | divided feedback signal; its rising edges are compared |
| tri_en | input | 1 | high disables the pump enables and the lock monitor |
| cur_code | input | 2 | requested pump current code |
| cur_load | input | 1 | strobe that captures `cur_code` |
| pump_up | output | 1 | pump source enable |
| pump_dn | output | 1 | pump sink enable |
| cur_sel | output | 2 | applied pump current level index |
| busy | output | 1 | pump active |
| locked | output | 1 | lock indication |

## Verification
A wrong detector state shows up as a wrong pulse width: a missed edge leaves an enable stuck high until the next comparison, and a broken reset path shows more or fewer than one overlap cycle within two clocks of the lagging edge. A wrong run count or an off-by-one window moves the rise or fall of `locked` by one comparison. The signed-gap sweep exposes this on the very comparison that crosses the window edge. A wrong pending-code state shows as `cur_sel` moving while the pump is busy, or not moving two clocks after an idle strobe.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int WIN_CYC  = 62,
  parameter int LOCK_RUN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       div_in,
  input  logic       tri_en,
  input  logic [1:0] cur_code,
  input  logic       cur_load,
  output logic       pump_up,
  output logic       pump_dn,
  output logic [1:0] cur_sel,
  output logic       busy,
  output logic       locked
);
  localparam int ERR_W = $clog2(WIN_CYC + 1);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(WIN_CYC);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

  logic             ref_q, div_q, up_q, dn_q, lock_q, pend_v;
  logic [ERR_W-1:0] err_cnt;
  logic [RUN_W-1:0] run_cnt;
  logic [1:0]       pend_code;

  wire ref_rise = ref_in & ~ref_q;
  wire div_rise = div_in & ~div_q;
  wire cmp_done = up_q & dn_q;
  wire in_win   = err_cnt < ERR_MAX;
  wire [RUN_W-1:0] run_inc = (run_cnt == RUN_MAX) ? run_cnt : run_cnt + 1'b1;

  assign pump_up = up_q & ~tri_en;
  assign pump_dn = dn_q & ~tri_en;
  assign busy    = pump_up | pump_dn;
  assign locked  = lock_q & ~tri_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      div_q <= div_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_cnt <= '0;
    end else if (tri_en || cmp_done) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_cnt <= '0;
    end else begin
      up_q <= up_q | ref_rise;
      dn_q <= dn_q | div_rise;
      if ((up_q ^ dn_q) && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lock_q  <= 1'b0;
    end else if (tri_en) begin
      run_cnt <= '0;
      lock_q  <= 1'b0;
    end else if (cmp_done) begin
      if (in_win) begin
        run_cnt <= run_inc;
        lock_q  <= run_inc == RUN_MAX;
      end else begin
        run_cnt <= '0;
        lock_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_code <= 2'b00;
      cur_sel   <= 2'b00;
    end else if (cur_load) begin
      pend_v    <= 1'b1;
      pend_code <= cur_code;
    end else if (pend_v && !busy) begin
      pend_v  <= 1'b0;
      cur_sel <= {pend_code[0], pend_code[1]};
    end
  end

  p_both_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q));

  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(cmp_done) && $past(in_win)));

  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && !in_win) |=> !lock_q);

  p_tri_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tri_en |=> (!up_q && !dn_q && !lock_q));

  p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_sel));

  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_MAX);
endmodule

// File: tb/sim_pfd_lock.sv
module sim_pfd_lock;
  localparam int WIN = 4;
  localparam int RUN = 7;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, div_in = 1'b0, tri_en = 1'b0, cur_load = 1'b0;
  logic [1:0] cur_code = 2'b00;
  logic pump_up, pump_dn, busy, locked;
  logic [1:0] cur_sel;
  int n_chk = 0, n_bad = 0, exp_run = 0;

  always #2 clk = ~clk;

  pfd_lock #(.WIN_CYC(WIN), .LOCK_RUN(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in), .tri_en(tri_en),
    .cur_code(cur_code), .cur_load(cur_load), .pump_up(pump_up), .pump_dn(pump_dn),
    .cur_sel(cur_sel), .busy(busy), .locked(locked));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input int d);
    int n = (d < 0) ? -d : d;
    int up_only = 0, dn_only = 0, both = 0, busy_bad = 0;
    @(negedge clk);
    if (d >= 0) ref_in = 1'b1; else div_in = 1'b1;
    if (n == 0) begin ref_in = 1'b1; div_in = 1'b1; end
    for (int k = 1; k <= n + 4; k++) begin
      @(negedge clk);
      if (pump_up && !pump_dn) up_only++;
      if (pump_dn && !pump_up) dn_only++;
      if (pump_up && pump_dn) both++;
      if (busy !== (pump_up | pump_dn)) busy_bad++;
      if (k == n) begin ref_in = 1'b1; div_in = 1'b1; end
    end
    ref_in = 1'b0; div_in = 1'b0;
    @(negedge clk);
    check(up_only == ((d > 0) ? d : 0), "R1 up-only width", up_only, (d > 0) ? d : 0);
    check(dn_only == ((d < 0) ? -d : 0), "R2 down-only width", dn_only, (d < 0) ? -d : 0);
    check(both == 1, "R3 overlap cycles", both, 1);
    check(busy_bad == 0, "R9 busy mismatch samples", busy_bad, 0);
    if (n < WIN) exp_run = (exp_run < RUN) ? exp_run + 1 : RUN;
    else exp_run = 0;
    check(locked == (exp_run == RUN), (n < WIN) ? "R4 lock after run" : "R5 lock cleared",
          locked, exp_run == RUN);
  endtask

  task automatic load(input logic [1:0] c);
    @(negedge clk); cur_code = c; cur_load = 1'b1;
    @(negedge clk); cur_load = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pump_up && !pump_dn && !busy && !locked, "R1 reset outputs idle", {pump_up, pump_dn, locked}, 0);
    check(cur_sel == 2'd0, "R7 reset level", cur_sel, 0);

    for (int d = -6; d <= 6; d++) cmp(d);
    for (int i = 0; i < RUN; i++) cmp(1);
    cmp(-WIN);
    for (int i = 0; i < RUN; i++) cmp(0);
    check(locked, "R4 locked before tri", locked, 1);

    @(negedge clk); tri_en = 1'b1;
    @(negedge clk);
    check(!locked, "R6 lock off under tri", locked, 0);
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    check(!pump_up && !pump_dn && !busy, "R6 pumps off under tri", {pump_up, pump_dn}, 0);
    div_in = 1'b1;
    repeat (2) @(negedge clk);
    check(!pump_up && !pump_dn && !locked, "R6 edges ignored under tri", {pump_up, pump_dn, locked}, 0);
    ref_in = 1'b0; div_in = 1'b0;
    @(negedge clk); tri_en = 1'b0;
    @(negedge clk);
    check(!locked && !busy, "R6 after tri release", {locked, busy}, 0);
    exp_run = 0;
    for (int i = 0; i < RUN; i++) cmp(2);

    for (int c = 0; c < 4; c++) begin
      logic [1:0] cc = 2'(c);
      load(cc);
      @(negedge clk);
      check(cur_sel == {cc[0], cc[1]}, "R7 code to level", cur_sel, {cc[0], cc[1]});
    end

    load(2'b10);
    @(negedge clk);
    check(cur_sel == 2'd1, "R8 idle apply", cur_sel, 1);
    @(negedge clk); ref_in = 1'b1;
    repeat (2) @(negedge clk);
    check(busy, "R9 busy while pumping", busy, 1);
    load(2'b11);
    repeat (3) @(negedge clk);
    check(cur_sel == 2'd1, "R8 held while busy", cur_sel, 1);
    div_in = 1'b1;
    @(negedge clk);
    check(cur_sel == 2'd1, "R8 held during overlap", cur_sel, 1);
    repeat (2) @(negedge clk);
    check(!busy && cur_sel == 2'd3, "R8 applied once idle", cur_sel, 3);
    ref_in = 1'b0; div_in = 1'b0;
    repeat (2) @(negedge clk);
    check(!locked, "R5 long gap leaves unlocked", locked, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule